// File: doc/BRIEF.md
# Outstanding Transaction ID Allocator

This block hands out unique 8-bit transaction IDs from one pool shared by every requester of a processor cluster. A request names a traffic class and the core that issues it. In the same cycle the block either grants it, returning the lowest-numbered free ID, or stalls it. Completions return IDs to the pool. Reads and writes draw on the same pool, and no ID is tied to a core. A value used for a read can later go to a write.

The block bounds concurrency at three levels. Each class has its own cap per core. Each core has a cap on its total reads. The cluster has caps on barriers, linefills from the coherent accelerator port and writes. The write cap follows from the core count and from whether a level-2 cache is present. With `NUM_CORES` cores, the pool holds `8*NUM_CORES + 4*HAS_ACP + (write cap + 1) + 1` IDs. With the defaults (4 cores, L2 and accelerator port present) this is 48 IDs, numbered 0 to 47.

For every allocated ID the block records the class and core, so a completion releases the right counters. A completion naming an ID that is not allocated changes nothing and raises a sticky error flag.

Top module: `txid_allocator`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), no ID is allocated, all counters are zero and cmp_err is 0. The first request then receives ID 0.
- R2: A request that has room is granted in the same cycle. grant_id is the lowest-numbered free ID in the range 0 to POOL-1. stall equals req_valid and not grant.
- R3: An ID is never granted while it is still outstanding, so all in-flight IDs are unique.
- R4: Writes (class code 9) are capped cluster-wide: 5 or 8 without L2 (one core, or two to four cores), and 7 or 10 with L2. With the defaults, the 11th outstanding write stalls.
- R5: A core has at most 8 per-core reads outstanding in total (class codes 0 to 6), whatever the class mix.
- R6: Per-core class caps apply: data linefill (code 0) 8, instruction linefill (1) 3, non-cacheable/device read (2) 4, page-walk read (3) 1, coherency operation (4) 5, DVM message (5) 8, exclusive sequence (6) 1.
- R7: Cluster caps ignore req_core: barrier (code 7) 1, accelerator-port linefill (code 8) 4 when HAS_ACP is 1 and 0 otherwise.
- R8: A stalled request consumes no ID and changes no counter. The next grant receives the same ID it would have received without the stalled request.
- R9: A completion frees its ID at the end of the cycle in which it arrives. The ID cannot be granted in that same cycle and can be granted from the next cycle on.
- R10: A completion releases the class and core counters recorded for that ID, which reopens room in them for the next request.
- R11: A completion naming an ID that is not allocated sets cmp_err, which stays at 1 until reset, and leaves every counter and every allocation unchanged.
- R12: A request with a class code from 10 to 15, or with a per-core class and req_core of NUM_CORES or more, is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_class | input | 4 | Traffic class code (0 to 9) |
| req_core | input | CORE_W (2) | Index of the requesting core |
| grant | output | 1 | Request granted this cycle |
| grant_id | output | ID_W (8) | ID assigned when grant is high |
| stall | output | 1 | Request present but refused |
| cmp_valid | input | 1 | Completion present this cycle |
| cmp_id | input | ID_W (8) | ID being retired |
| cmp_err | output | 1 | Sticky flag for a completion of an unallocated ID |

## Verification
The hardest state to reach from the ports is a cap that is full while other caps still have room. Examples are a core at eight reads with its individual class counters below their limits, or the write cap reached while the pool still holds plenty of IDs. The stimulus builds each one on top of what is already outstanding. It fills instruction linefills and coherency operations on one core and then offers a DVM message. It adds writes until the cluster cap refuses one. It fills accelerator-port and device-read slots to their limits. A completion then retires one specific entry and the blocked request is offered again, which shows that the recorded class and core, and not the ID value, decide which counter reopens.

// File: rtl/txid_pkg.sv
// Package: shared constants, class encoding and cap functions for the
// transaction ID allocator. Assumes per-core classes use codes 0..6 and
// cluster-wide classes use codes 7..9.
package txid_pkg;

    localparam int NUM_CLASSES      = 10;
    localparam int NUM_CORE_CLASSES = 7;
    localparam int NUM_CLU_CLASSES  = 3;
    localparam int CORE_READ_CAP    = 8;
    localparam int CNT_W            = 5;

    typedef enum logic [3:0] {
        CL_DLINE = 4'd0,
        CL_ILINE = 4'd1,
        CL_NCDEV = 4'd2,
        CL_WALK  = 4'd3,
        CL_COH   = 4'd4,
        CL_DVM   = 4'd5,
        CL_EXCL  = 4'd6,
        CL_BARR  = 4'd7,
        CL_ACP   = 4'd8,
        CL_WRITE = 4'd9
    } txn_class_e;

    // Cluster write cap from core count and L2 presence.
    function automatic int write_cap(input int cores, input int has_l2);
        if (has_l2 != 0) return (cores == 1) ? 7 : 10;
        return (cores == 1) ? 5 : 8;
    endfunction

    // Concurrent cap of one class; unknown codes get zero.
    function automatic logic [CNT_W-1:0] class_cap(input logic [3:0] cls,
                                                  input int wcap,
                                                  input int has_acp);
        case (cls)
            CL_DLINE: return CNT_W'(8);
            CL_ILINE: return CNT_W'(3);
            CL_NCDEV: return CNT_W'(4);
            CL_WALK:  return CNT_W'(1);
            CL_COH:   return CNT_W'(5);
            CL_DVM:   return CNT_W'(8);
            CL_EXCL:  return CNT_W'(1);
            CL_BARR:  return CNT_W'(1);
            CL_ACP:   return (has_acp != 0) ? CNT_W'(4) : CNT_W'(0);
            CL_WRITE: return CNT_W'(wcap);
            default:  return CNT_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/txid_free_pool.sv
// Module: free-ID bitmap with a lowest-index-first search.
// Assumes take is only raised when free_any is high; a completion
// clears its bit at the clock edge ending the cycle it arrives in.
module txid_free_pool #(
    parameter int POOL = 48,
    parameter int ID_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic            cmp_valid,
    input  logic [ID_W-1:0] cmp_id,
    output logic            free_any,
    output logic [ID_W-1:0] free_id,
    output logic            cmp_hit
);

    logic [POOL-1:0] alloc_q;

    // Find the lowest-numbered free ID.
    always_comb begin
        free_any = 1'b0;
        free_id  = '0;
        for (int i = POOL - 1; i >= 0; i--) begin
            if (!alloc_q[i]) begin
                free_any = 1'b1;
                free_id  = ID_W'(i);
            end
        end
    end

    // Flag a completion that names a currently allocated ID.
    always_comb begin
        cmp_hit = 1'b0;
        for (int i = 0; i < POOL; i++) begin
            if (cmp_valid && cmp_id == ID_W'(i) && alloc_q[i]) cmp_hit = 1'b1;
        end
    end

    // Mark IDs taken on grant and released on a valid completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alloc_q <= '0;
        end else begin
            for (int i = 0; i < POOL; i++) begin
                if (take && free_id == ID_W'(i)) alloc_q[i] <= 1'b1;
                else if (cmp_hit && cmp_id == ID_W'(i)) alloc_q[i] <= 1'b0;
            end
        end
    end

    for (genvar i = 0; i < POOL; i++) begin : g_chk
        // R3: a granted ID is held from the next cycle on
        a_r3_taken_held: assert property (@(posedge clk) disable iff (!rst_n)
            (take && free_id == ID_W'(i)) |=> alloc_q[i]);
        // R9: a completed ID is free again in the next cycle
        a_r9_freed_next: assert property (@(posedge clk) disable iff (!rst_n)
            (cmp_valid && cmp_id == ID_W'(i) && alloc_q[i]) |=> !alloc_q[i]);
    end

endmodule

// File: rtl/txid_tag_table.sv
// Module: per-ID record of class and core, written on grant and read
// combinationally by the completion path. Out-of-range reads return 0.
module txid_tag_table #(
    parameter int POOL   = 48,
    parameter int ID_W   = 8,
    parameter int CORE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [3:0]        wr_cls,
    input  logic [CORE_W-1:0] wr_core,
    input  logic [ID_W-1:0]   rd_id,
    output logic [3:0]        rd_cls,
    output logic [CORE_W-1:0] rd_core
);

    logic [3:0]        cls_q  [POOL];
    logic [CORE_W-1:0] core_q [POOL];

    // Store the owner of an ID when it is granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < POOL; i++) begin
                cls_q[i]  <= '0;
                core_q[i] <= '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < POOL; i++) begin
                if (wr_id == ID_W'(i)) begin
                    cls_q[i]  <= wr_cls;
                    core_q[i] <= wr_core;
                end
            end
        end
    end

    // Look up the owner of a completing ID.
    always_comb begin
        rd_cls  = '0;
        rd_core = '0;
        for (int i = 0; i < POOL; i++) begin
            if (rd_id == ID_W'(i)) begin
                rd_cls  = cls_q[i];
                rd_core = core_q[i];
            end
        end
    end

endmodule

// File: rtl/txid_cap_track.sv
// Module: outstanding counters per core and class, per core total, and
// cluster-wide for barrier, accelerator-port linefill and write.
// Reports whether the presented request has room under every cap.
// Assumes inc only when the request is granted and dec only for an ID
// that is really allocated.
module txid_cap_track
    import txid_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int CORE_W    = 2,
    parameter int WCAP      = 10,
    parameter int HAS_ACP   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        req_cls,
    input  logic [CORE_W-1:0] req_core,
    input  logic              inc,
    input  logic              dec,
    input  logic [3:0]        dec_cls,
    input  logic [CORE_W-1:0] dec_core,
    output logic              room
);

    logic [CNT_W-1:0]     cap_req;
    logic                 is_core_req;
    logic                 is_clu_req;
    logic                 core_ok;
    logic                 dec_is_core;
    logic [NUM_CORES-1:0] core_cls_room;
    logic [NUM_CORES-1:0] core_tot_room;
    logic                 sel_cls_room;
    logic                 sel_tot_room;
    logic                 clu_room;

    // Decode the request's class group and its cap.
    always_comb begin
        cap_req     = class_cap(req_cls, WCAP, HAS_ACP);
        is_core_req = req_cls < 4'(NUM_CORE_CLASSES);
        is_clu_req  = !is_core_req && req_cls < 4'(NUM_CLASSES);
        core_ok     = int'(req_core) < NUM_CORES;
        dec_is_core = dec_cls < 4'(NUM_CORE_CLASSES);
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic [CNT_W-1:0]            cnt_q [NUM_CORE_CLASSES];
        logic [CNT_W-1:0]            tot_q;
        logic                        inc_c;
        logic                        dec_c;
        logic [NUM_CORE_CLASSES-1:0] inc_v;
        logic [NUM_CORE_CLASSES-1:0] dec_v;
        logic                        room_c;

        // Steer the increment and decrement to this core's classes.
        always_comb begin
            inc_c = inc && is_core_req && req_core == CORE_W'(c);
            dec_c = dec && dec_is_core && dec_core == CORE_W'(c);
            for (int k = 0; k < NUM_CORE_CLASSES; k++) begin
                inc_v[k] = inc_c && req_cls == 4'(k);
                dec_v[k] = dec_c && dec_cls == 4'(k);
            end
        end

        // Count outstanding reads of this core per class and in total.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tot_q <= '0;
                for (int k = 0; k < NUM_CORE_CLASSES; k++) cnt_q[k] <= '0;
            end else begin
                for (int k = 0; k < NUM_CORE_CLASSES; k++) begin
                    if (inc_v[k] && !dec_v[k]) cnt_q[k] <= cnt_q[k] + 1'b1;
                    else if (dec_v[k] && !inc_v[k]) cnt_q[k] <= cnt_q[k] - 1'b1;
                end
                if (inc_c && !dec_c) tot_q <= tot_q + 1'b1;
                else if (dec_c && !inc_c) tot_q <= tot_q - 1'b1;
            end
        end

        // Room left in the requested class of this core.
        always_comb begin
            room_c = 1'b0;
            for (int k = 0; k < NUM_CORE_CLASSES; k++) begin
                if (req_cls == 4'(k)) room_c = cnt_q[k] < cap_req;
            end
        end

        assign core_cls_room[c] = room_c;
        assign core_tot_room[c] = tot_q < CNT_W'(CORE_READ_CAP);

        // R5: a core never exceeds eight outstanding reads
        a_r5_core_read_cap: assert property (@(posedge clk) disable iff (!rst_n)
            tot_q <= CNT_W'(CORE_READ_CAP));
        // R10: a completion only releases a counter that holds entries
        a_r10_dec_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
            dec_c |-> tot_q != '0);
    end

    // Select the per-core room flags of the requesting core.
    always_comb begin
        sel_cls_room = 1'b0;
        sel_tot_room = 1'b0;
        for (int c = 0; c < NUM_CORES; c++) begin
            if (req_core == CORE_W'(c)) begin
                sel_cls_room = core_cls_room[c];
                sel_tot_room = core_tot_room[c];
            end
        end
    end

    logic [CNT_W-1:0]           clu_q [NUM_CLU_CLASSES];
    logic [NUM_CLU_CLASSES-1:0] clu_inc;
    logic [NUM_CLU_CLASSES-1:0] clu_dec;

    // Steer cluster-wide increments and decrements by class.
    always_comb begin
        clu_room = 1'b0;
        for (int k = 0; k < NUM_CLU_CLASSES; k++) begin
            clu_inc[k] = inc && req_cls == 4'(NUM_CORE_CLASSES + k);
            clu_dec[k] = dec && dec_cls == 4'(NUM_CORE_CLASSES + k);
            if (req_cls == 4'(NUM_CORE_CLASSES + k)) clu_room = clu_q[k] < cap_req;
        end
    end

    // Count cluster-wide outstanding barriers, port linefills and writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_CLU_CLASSES; k++) clu_q[k] <= '0;
        end else begin
            for (int k = 0; k < NUM_CLU_CLASSES; k++) begin
                if (clu_inc[k] && !clu_dec[k]) clu_q[k] <= clu_q[k] + 1'b1;
                else if (clu_dec[k] && !clu_inc[k]) clu_q[k] <= clu_q[k] - 1'b1;
            end
        end
    end

    // Combine every cap check for the presented request.
    always_comb begin
        if (is_core_req) room = core_ok && sel_cls_room && sel_tot_room;
        else if (is_clu_req) room = clu_room;
        else room = 1'b0;
    end

    // R7: at most one barrier outstanding
    a_r7_barrier_cap: assert property (@(posedge clk) disable iff (!rst_n)
        clu_q[0] <= CNT_W'(1));
    // R7: port linefills bounded by four
    a_r7_acp_cap: assert property (@(posedge clk) disable iff (!rst_n)
        clu_q[1] <= CNT_W'(4 * HAS_ACP));
    // R4: writes bounded by the configured cap
    a_r4_write_cap: assert property (@(posedge clk) disable iff (!rst_n)
        clu_q[2] <= CNT_W'(WCAP));

endmodule

// File: rtl/txid_allocator.sv
// Module: top of the transaction ID allocator. Grants the lowest free ID
// when every cap has room, records the owner of the ID and releases it on
// completion. Assumes at most one request and one completion per cycle.
module txid_allocator
    import txid_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int HAS_L2    = 1,
    parameter int HAS_ACP   = 1,
    parameter int ID_W      = 8,
    localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [3:0]        req_class,
    input  logic [CORE_W-1:0] req_core,
    output logic              grant,
    output logic [ID_W-1:0]   grant_id,
    output logic              stall,
    input  logic              cmp_valid,
    input  logic [ID_W-1:0]   cmp_id,
    output logic              cmp_err
);

    localparam int WCAP = write_cap(NUM_CORES, HAS_L2);
    localparam int POOL = 8 * NUM_CORES + 4 * HAS_ACP + (WCAP + 1) + 1;

    logic              free_any;
    logic [ID_W-1:0]   free_id;
    logic              cmp_hit;
    logic              room;
    logic [3:0]        dec_cls;
    logic [CORE_W-1:0] dec_core;
    logic              err_q;

    txid_free_pool #(.POOL(POOL), .ID_W(ID_W)) u_pool (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (grant),
        .cmp_valid (cmp_valid),
        .cmp_id    (cmp_id),
        .free_any  (free_any),
        .free_id   (free_id),
        .cmp_hit   (cmp_hit)
    );

    txid_tag_table #(.POOL(POOL), .ID_W(ID_W), .CORE_W(CORE_W)) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (grant),
        .wr_id   (free_id),
        .wr_cls  (req_class),
        .wr_core (req_core),
        .rd_id   (cmp_id),
        .rd_cls  (dec_cls),
        .rd_core (dec_core)
    );

    txid_cap_track #(
        .NUM_CORES (NUM_CORES),
        .CORE_W    (CORE_W),
        .WCAP      (WCAP),
        .HAS_ACP   (HAS_ACP)
    ) u_caps (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_cls  (req_class),
        .req_core (req_core),
        .inc      (grant),
        .dec      (cmp_hit),
        .dec_cls  (dec_cls),
        .dec_core (dec_core),
        .room     (room)
    );

    // Grant only when caps and pool both have room.
    always_comb begin
        grant    = req_valid && room && free_any;
        grant_id = free_id;
        stall    = req_valid && !grant;
    end

    // Latch a completion of an unallocated ID until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else if (cmp_valid && !cmp_hit) err_q <= 1'b1;
    end

    assign cmp_err = err_q;

    // R2: a grant needs a request
    a_r2_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> req_valid);
    // R2: granted IDs stay inside the pool
    a_r2_id_in_pool: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (int'(grant_id) < POOL));
    // R11: the error flag is sticky
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_err |=> cmp_err);
    // R12: undefined class codes are never granted
    a_r12_bad_class: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_class >= 4'(NUM_CLASSES)) |-> !grant);

endmodule

// File: tb/txid_allocator_tb.sv
module txid_allocator_tb;

    localparam int POOL = 48;   // 8*4 + 4 + 11 + 1

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [3:0] req_class = '0;
    logic [1:0] req_core = '0;
    logic       grant;
    logic [7:0] grant_id;
    logic       stall;
    logic       cmp_valid = 1'b0;
    logic [7:0] cmp_id = '0;
    logic       cmp_err;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  mdl [POOL];
    int  got;
    int  coh_id;

    always #2 clk = ~clk;

    txid_allocator u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
        .req_core(req_core), .grant(grant), .grant_id(grant_id), .stall(stall),
        .cmp_valid(cmp_valid), .cmp_id(cmp_id), .cmp_err(cmp_err)
    );

    typedef struct packed {
        logic       rv;
        logic [3:0] cls;
        logic [1:0] core;
        logic       cv;
        logic [7:0] cid;
        logic       eg;
        logic [7:0] eid;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'd0, 2'd0, 1'b0, 8'd0,  1'b1, 8'd0},  // R2 dline core0
        '{1'b1, 4'd1, 2'd1, 1'b0, 8'd0,  1'b1, 8'd1},  // R2 iline core1
        '{1'b1, 4'd9, 2'd0, 1'b0, 8'd0,  1'b1, 8'd2},  // R2 write
        '{1'b1, 4'd3, 2'd2, 1'b1, 8'd1,  1'b1, 8'd3},  // R9 id1 not reused same cycle
        '{1'b1, 4'd7, 2'd0, 1'b0, 8'd0,  1'b1, 8'd1},  // R9 id1 reused next cycle
        '{1'b1, 4'd7, 2'd1, 1'b0, 8'd0,  1'b0, 8'd0},  // R7 second barrier
        '{1'b1, 4'd3, 2'd2, 1'b0, 8'd0,  1'b0, 8'd0},  // R6 walk cap 1
        '{1'b1, 4'd12, 2'd0, 1'b0, 8'd0, 1'b0, 8'd0},  // R12 bad class
        '{1'b1, 4'd6, 2'd0, 1'b0, 8'd0,  1'b1, 8'd4},  // R8 stalls took nothing
        '{1'b1, 4'd6, 2'd0, 1'b0, 8'd0,  1'b0, 8'd0},  // R6 exclusive cap 1
        '{1'b0, 4'd0, 2'd0, 1'b1, 8'd4,  1'b0, 8'd0},  // R10 retire exclusive
        '{1'b1, 4'd6, 2'd0, 1'b0, 8'd0,  1'b1, 8'd4},  // R10 exclusive again
        '{1'b0, 4'd0, 2'd0, 1'b1, 8'd30, 1'b0, 8'd0}   // R11 bad completion
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int lowest_free();
        for (int i = 0; i < POOL; i++) if (!mdl[i]) return i;
        return -1;
    endfunction

    task automatic step(input logic rv, input logic [3:0] cls, input logic [1:0] core,
                        input logic cv, input logic [7:0] cid);
        @(negedge clk);
        req_valid = rv; req_class = cls; req_core = core;
        cmp_valid = cv; cmp_id = cid;
        #1;
    endtask

    task automatic do_req(input logic [3:0] cls, input logic [1:0] core,
                          input bit exp_g, input string req, output int id);
        int e;
        e = lowest_free();
        step(1'b1, cls, core, 1'b0, 8'd0);
        chk(grant == exp_g, {req, " grant"}, int'(grant), int'(exp_g));
        chk(stall == !exp_g, {req, " stall"}, int'(stall), int'(!exp_g));
        id = -1;
        if (exp_g && grant) begin
            // R3: the expected ID is the lowest one not outstanding
            chk(int'(grant_id) == e, {req, " id"}, int'(grant_id), e);
            mdl[e] = 1'b1;
            id = e;
        end
    endtask

    task automatic do_cmp(input int id);
        step(1'b0, 4'd0, 2'd0, 1'b1, 8'(id));
        if (id < POOL) mdl[id] = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < POOL; i++) mdl[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(grant == 1'b0, "R1 grant idle", int'(grant), 0);
        chk(cmp_err == 1'b0, "R1 err clear", int'(cmp_err), 0);

        for (int v = 0; v < NV; v++) begin
            step(VECS[v].rv, VECS[v].cls, VECS[v].core, VECS[v].cv, VECS[v].cid);
            chk(grant == VECS[v].eg, $sformatf("R2 vec%0d grant", v), int'(grant), int'(VECS[v].eg));
            chk(stall == (VECS[v].rv && !VECS[v].eg), $sformatf("R2 vec%0d stall", v),
                int'(stall), int'(VECS[v].rv && !VECS[v].eg));
            if (VECS[v].eg)
                chk(grant_id == VECS[v].eid, $sformatf("R2 vec%0d id", v),
                    int'(grant_id), int'(VECS[v].eid));
            if (VECS[v].cv && VECS[v].cid < POOL) mdl[VECS[v].cid] = 1'b0;
            if (VECS[v].eg) mdl[VECS[v].eid] = 1'b1;
        end

        step(1'b0, 4'd0, 2'd0, 1'b0, 8'd0);
        chk(cmp_err == 1'b1, "R11 err set", int'(cmp_err), 1);
        do_req(4'd3, 2'd2, 1'b0, "R11 walk counter unchanged", got);
        chk(cmp_err == 1'b1, "R11 err sticky", int'(cmp_err), 1);

        // R4: one write outstanding, nine more fit, then stall
        for (int i = 0; i < 9; i++) do_req(4'd9, 2'd0, 1'b1, "R4 write", got);
        do_req(4'd9, 2'd3, 1'b0, "R4 write cap", got);

        // R6 and R5 on core1
        for (int i = 0; i < 3; i++) do_req(4'd1, 2'd1, 1'b1, "R6 iline", got);
        do_req(4'd1, 2'd1, 1'b0, "R6 iline cap", got);
        coh_id = -1;
        for (int i = 0; i < 5; i++) begin
            do_req(4'd4, 2'd1, 1'b1, "R5 coh", got);
            if (i == 2) coh_id = got;
        end
        do_req(4'd5, 2'd1, 1'b0, "R5 core total cap", got);
        do_req(4'd5, 2'd3, 1'b1, "R5 other core free", got);

        // R6 device reads on core3
        for (int i = 0; i < 4; i++) do_req(4'd2, 2'd3, 1'b1, "R6 ncdev", got);
        do_req(4'd2, 2'd3, 1'b0, "R6 ncdev cap", got);

        // R7 port linefills
        for (int i = 0; i < 4; i++) do_req(4'd8, 2'd0, 1'b1, "R7 acp", got);
        do_req(4'd8, 2'd2, 1'b0, "R7 acp cap", got);

        // R10: retiring a coherency entry reopens core1
        do_cmp(coh_id);
        do_req(4'd5, 2'd1, 1'b1, "R10 dvm after retire", got);
        chk(got == coh_id, "R10 reused id", got, coh_id);

        // R10: retiring the barrier reopens the cluster barrier slot
        do_cmp(1);
        do_req(4'd7, 2'd3, 1'b1, "R10 barrier again", got);

        // R1: reset in the middle of traffic
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; cmp_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < POOL; i++) mdl[i] = 1'b0;
        #1;
        chk(cmp_err == 1'b0, "R1 err after reset", int'(cmp_err), 0);
        do_req(4'd9, 2'd0, 1'b1, "R1 first id after reset", got);
        chk(got == 0, "R1 id zero", got, 0);

        step(1'b0, 4'd0, 2'd0, 1'b0, 8'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule